// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a 32-bit word of asynchronous digital inputs and raises a level interrupt when a configured change-of-state condition is met. Only a contiguous window of channels, 4 to 19 by default, can take part in the trigger. Every input can still be read as raw data.

Software configures the block through a small word-addressed register port with read and write strobes. It sets one mask for channels that react high or rising and one mask for channels that react low or falling. It then picks one of two combining modes:
- In OR mode, any selected edge fires the interrupt.
- In AND mode, the interrupt fires only when every selected channel sits at its chosen level at the same time. After firing in AND mode, a level change on a selected channel must occur before the block can fire again.

When the interrupt fires, the block latches a snapshot of the trigger-capable channels. Software reads this snapshot and acknowledges the interrupt by briefly clearing the enable bit.

Top module: `cos_irq_ctrl`

## Requirements
- R1: The rise/high mask (address 1) and the fall/low mask (address 2) store only bits 19:4 and read back zero elsewhere (a write of 0xFFFFFFFF reads back 0x000FFFF0). Inputs outside bits 19:4 never cause an interrupt.
- R2: In OR mode, a bit set in the address-1 mask selects a rising edge on that channel. A bit set in the address-2 mask selects a falling edge. An edge of the other polarity on that channel does not fire.
- R3: After reset, the masks, the control register, the status register and `irq` are all zero. Writing zero to control and both masks leaves `irq` low whatever the inputs do.
- R4: The control register is at address 4. Bit 2 is the enable and bit 1 selects AND mode when 1 or OR mode when 0; the other bits read as zero. In OR mode with enable set, a selected edge raises `irq` on the third rising clock edge after the input changes.
- R5: In AND mode with enable set, `irq` fires when all high-selected channels are 1 and all low-selected channels are 0 at once. After firing, it does not fire again until some selected channel changes level.
- R6: Reading address 3 returns the input state captured at the last firing, limited to bits 19:4. That read clears the captured value to zero.
- R7: A write to address 4 with bit 2 clear drops `irq` on that clock edge. Rewriting the previous value re-enables detection without a new interrupt, unless a new condition occurs.
- R8: Once raised, `irq` stays high until it is acknowledged, even if the input condition goes away.
- R9: Reading address 0 returns the synchronised state of all 32 inputs at any time. The read has no side effect on `irq` or on the status register.
- R10: Read data appears on `rdata` one clock after the cycle in which `rd_en` is sampled high, and holds until the next read. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | Asynchronous digital inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
Most internal faults show up at the `irq` pin within three clocks of an input change. A wrong edge polarity, a missing enable gate or a misplaced channel window makes `irq` rise where it should not, or stay low where it should rise. A broken re-arm flag in AND mode shows up as an extra interrupt right after an acknowledge, or as a missing one after the selected inputs toggle. Faults in the snapshot or the read-clear path show on `rdata` one clock after a status read, and a second read exposes a clear that never happened.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  localparam int ADDR_W  = 3;
  localparam int EN_BIT  = 2;
  localparam int AND_BIT = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW  = 3'd0,
    REG_RISE = 3'd1,
    REG_FALL = 3'd2,
    REG_STAT = 3'd3,
    REG_CTRL = 3'd4
  } cos_reg_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= '0;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         and_mode,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] rise_m,
  input  logic [W-1:0] fall_m,
  output logic         fire
);
  logic [W-1:0] prev_q;
  logic         armed_q;
  logic [W-1:0] rise_ev, fall_ev, sel;
  logic         or_hit, lvl_ok, sel_chg, and_hit;

  always_comb begin
    rise_ev = cur & ~prev_q & rise_m;
    fall_ev = ~cur & prev_q & fall_m;
    or_hit  = |(rise_ev | fall_ev);
    sel     = rise_m | fall_m;
    lvl_ok  = (|sel) && ((cur & rise_m) == rise_m) && ((~cur & fall_m) == fall_m);
    sel_chg = |((cur ^ prev_q) & sel);
    and_hit = lvl_ok && (armed_q || sel_chg);
    fire    = en && (and_mode ? and_hit : or_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      prev_q <= cur;
      if (fire && and_mode) armed_q <= 1'b0;
      else if (sel_chg)     armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cos_capture.sv
module cos_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         fire,
  input  logic         ack_clr,
  input  logic         rd_clr,
  input  logic [W-1:0] snap,
  output logic         irq,
  output logic [W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      status <= '0;
    end else begin
      if (fire)        status <= snap;
      else if (rd_clr) status <= '0;

      if (ack_clr || !en) irq <= 1'b0;
      else if (fire)      irq <= 1'b1;
    end
  end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CH_LO  = 4,
  parameter int CH_HI  = 19,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     din,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam logic [DW-1:0] ONES    = '1;
  localparam logic [DW-1:0] CH_MASK = (ONES >> (DW-1-CH_HI)) & (ONES << CH_LO);

  logic [DW-1:0] din_s, rise_q, fall_q, status, rdata_q;
  logic          en_q, and_q, fire, ack_clr, rd_clr;

  cos_sync #(.W(DW), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(din), .q(din_s)
  );

  cos_detect #(.W(DW)) u_detect (
    .clk(clk), .rst(rst), .en(en_q), .and_mode(and_q),
    .cur(din_s), .rise_m(rise_q), .fall_m(fall_q), .fire(fire)
  );

  assign ack_clr = wr_en && (addr == REG_CTRL) && !wdata[EN_BIT];
  assign rd_clr  = rd_en && (addr == REG_STAT);

  cos_capture #(.W(DW)) u_capture (
    .clk(clk), .rst(rst), .en(en_q), .fire(fire), .ack_clr(ack_clr),
    .rd_clr(rd_clr), .snap(din_s & CH_MASK), .irq(irq), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
      en_q   <= 1'b0;
      and_q  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        REG_RISE: rise_q <= wdata & CH_MASK;
        REG_FALL: fall_q <= wdata & CH_MASK;
        REG_CTRL: begin
          en_q  <= wdata[EN_BIT];
          and_q <= wdata[AND_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en) begin
      case (addr)
        REG_RAW:  rdata_q <= din_s;
        REG_RISE: rdata_q <= rise_q;
        REG_FALL: rdata_q <= fall_q;
        REG_STAT: rdata_q <= status;
        REG_CTRL: begin
          rdata_q          <= '0;
          rdata_q[EN_BIT]  <= en_q;
          rdata_q[AND_BIT] <= and_q;
        end
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int DW    = 32,
  parameter int CH_LO = 4,
  parameter int CH_HI = 19
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic          en_q
);
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] WIN  = (ONES >> (DW-1-CH_HI)) & (ONES << CH_LO);

  logic ack_w;
  assign ack_w = wr_en && (addr == 3'd4) && !wdata[2];

  a_r1_mask_window: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == 3'd1 || addr == 3'd2)) |=> ((rdata & ~WIN) == '0));

  a_r6_status_window: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd3) |=> ((rdata & ~WIN) == '0));

  a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
    ack_w |=> !irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack_w && en_q) |=> irq);

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!irq && !en_q) |=> !irq);
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.DW(DW), .CH_LO(CH_LO), .CH_HI(CH_HI)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .en_q(en_q)
);

// File: tb/cos_irq_ctrl_tb.sv
module cos_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN = 32'h000F_FFF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .din(din), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  logic [31:0] m_s1, m_s2, m_prev, m_rise, m_fall, m_stat, m_rdata;
  logic        m_en, m_and, m_irq, m_armed;
  always @(posedge clk) begin
    logic [31:0] sel;
    logic fire, chg, lvl, orh, ack;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_rise = 0; m_fall = 0; m_stat = 0;
      m_rdata = 0; m_en = 0; m_and = 0; m_irq = 0; m_armed = 1;
    end else begin
      sel  = m_rise | m_fall;
      orh  = ((m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall)) != 0;
      lvl  = (sel != 0) && ((m_s2 & m_rise) == m_rise) && ((~m_s2 & m_fall) == m_fall);
      chg  = ((m_s2 ^ m_prev) & sel) != 0;
      fire = m_en && (m_and ? (lvl && (m_armed || chg)) : orh);
      ack  = wr_en && addr == 4 && !wdata[2];
      if (rd_en) begin
        case (addr)
          0: m_rdata = m_s2;
          1: m_rdata = m_rise;
          2: m_rdata = m_fall;
          3: m_rdata = m_stat;
          4: m_rdata = {29'b0, m_en, m_and, 1'b0};
          default: m_rdata = 0;
        endcase
      end
      if (fire) m_stat = m_s2 & WIN;
      else if (rd_en && addr == 3) m_stat = 0;
      if (ack || !m_en) m_irq = 0;
      else if (fire) m_irq = 1;
      if (fire && m_and) m_armed = 0;
      else if (chg) m_armed = 1;
      if (wr_en) begin
        if (addr == 1) m_rise = wdata & WIN;
        if (addr == 2) m_fall = wdata & WIN;
        if (addr == 4) begin m_en = wdata[2]; m_and = wdata[1]; end
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = din;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 R5 R8 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      chk("R10 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R3 irq after reset", {31'b0, irq}, 0);
    rd(4, v); chk("R3 ctrl after reset", v, 0);
    rd(3, v); chk("R3 status after reset", v, 0);

    wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R1 rise mask window", v, 32'h000F_FFF0);
    wr(2, 32'h0000_000F); rd(2, v); chk("R1 fall mask window", v, 0);
    wr(4, 32'hFFFF_FFFF); rd(4, v); chk("R4 ctrl readback", v, 32'h6);
    wr(4, 0); wr(2, 0);

    // OR mode, rising on channel 5
    wr(1, 32'h20); wr(4, 32'h4);
    din = 32'h4; settle();
    chk("R1 channel 2 cannot trigger", {31'b0, irq}, 0);
    din = 32'h24; settle();
    chk("R4 OR rising fires", {31'b0, irq}, 1);
    rd(3, v); chk("R6 status snapshot", v, 32'h20);
    rd(3, v); chk("R6 status cleared by read", v, 0);
    din = 32'h4; settle();
    chk("R8 irq held after condition leaves", {31'b0, irq}, 1);
    chk("R2 falling not selected no snapshot", m_stat, 0);
    rd(0, v); chk("R9 raw input", v, 32'h4);
    chk("R9 raw read leaves irq", {31'b0, irq}, 1);
    wr(4, 0); chk("R7 ack drops irq", {31'b0, irq}, 0);
    wr(4, 32'h4); settle();
    chk("R7 re-enable no new irq", {31'b0, irq}, 0);

    // OR mode, falling on channel 8
    wr(1, 0); wr(2, 32'h100);
    din = 32'h104; settle();
    chk("R2 rising on fall-selected ignored", {31'b0, irq}, 0);
    din = 32'h4; settle();
    chk("R2 falling fires", {31'b0, irq}, 1);
    wr(4, 0); wr(4, 32'h4);

    // AND mode: channel 4 high, channel 6 low
    wr(4, 0); wr(1, 32'h10); wr(2, 32'h40); wr(4, 32'h6);
    settle();
    chk("R5 AND condition not met", {31'b0, irq}, 0);
    din = 32'h14; settle();
    chk("R5 AND fires", {31'b0, irq}, 1);
    rd(3, v); chk("R6 AND snapshot", v, 32'h10);
    wr(4, 32'h2); wr(4, 32'h6); settle();
    chk("R5 no refire without change", {31'b0, irq}, 0);
    din = 32'h214; settle();
    chk("R5 unselected change does not re-arm fire", {31'b0, irq}, 0);
    din = 32'h204; settle();
    chk("R5 condition false", {31'b0, irq}, 0);
    din = 32'h214; settle();
    chk("R5 refires after level change", {31'b0, irq}, 1);
    wr(4, 32'h2); wr(4, 32'h6);
    din = 32'h254; settle();
    chk("R5 low channel violated", {31'b0, irq}, 0);

    // full disable
    wr(4, 0); wr(1, 0); wr(2, 0);
    for (int i = 0; i < 6; i++) begin
      din = ~din ^ (32'h1 << i);
      settle();
    end
    chk("R3 disabled stays quiet", {31'b0, irq}, 0);
    rd(1, v); chk("R3 rise mask zero", v, 0);
    rd(7, v); chk("R10 unmapped reads zero", v, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule